// File: doc/BRIEF.md
# MDIO Management Master with Extended-Register Sequencer

This block gives a controller access to the management registers of an Ethernet PHY over the two-wire management bus. MDC is the management clock and MDIO is the bidirectional data line. Software works through two words of a simple register port. The command word holds a start/busy bit, a write flag, an extended-write flag, a clock-range selector and a register number. The data word holds a 16-bit payload and, in its upper half, the target address used for an extended write. Writing the command word with the start bit set launches a transaction. The busy bit then stays high until the last MDIO frame has left the wire.

A plain command runs one read or one write frame. With the extended flag set, a small sequencer instead issues four back-to-back write frames. Together they form the indirect access that reaches the PHY's extended register space. The first pair of frames selects the target address. The second pair delivers the data. Busy covers the whole four-frame run. Read results land in the low half of the data word once busy drops.

Top module: `mdio_mgmt_master`

## Requirements
- R1: A write to the command word (select 0) with bit 0 set and busy low starts a transaction. Bit 0 of the command word reads 1 from the next cycle. It returns to 0 only after the final MDC falling edge of the last frame, when MDC is back low.
- R2: While busy is high, writes to the command word and to the data word have no effect on any register, on the frames sent, or on the read result.
- R3: The command word carries an 8-bit register number in bits [15:8]. Only its low 5 bits are kept. They read back in bits [12:8], with bits [15:13] reading 0, and they are the 5 bits sent on the wire.
- R4: A plain write (command bit 1 = 1, bit 2 = 0) sends 64 MDC cycles in this order: 32 ones, 01, opcode 01, the 5-bit PHY address, the 5-bit register number, 10, then data-word bits [15:0] MSB first.
- R5: A plain read (command bit 1 = 0, bit 2 = 0) sends opcode 10. It releases MDIO (output enable low) from the first turnaround bit through the last data bit. It samples 16 bits on the rising edges of MDC, MSB first, into data-word bits [15:0].
- R6: An extended write (command bit 2 = 1, write flag ignored) sends four write frames in order: register 0x0D with 0x001F, register 0x0E with the target (data-word bits [31:16]), register 0x0D with 0x401F, and register 0x0E with data-word bits [15:0].
- R7: The MDC period is 8 << range system clocks, where range is command bits [4:3]. MDC stays low whenever no frame is active.
- R8: MDIO output never changes in the system clock cycle in which MDC rises.
- R9: After reset the command word and the data word read 0, MDC is low and MDIO is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register port write strobe |
| reg_sel | input | 1 | Write target: 0 command word, 1 data word |
| reg_wdata | input | 32 | Write data |
| reg_rsel | input | 1 | Read select: 0 command word, 1 data word |
| reg_rdata | output | 32 | Read data of the selected word |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (low means released) |
| mdio_i | input | 1 | MDIO input value |

## Verification
A bench PHY model decodes every frame on the wire and answers reads from its own register file. Directed cases cover a plain write, a read of the value just written, a register number with its upper bits set, and commands and data writes issued mid-transaction. They also cover an extended write and one frame at each clock range. Together these separate opcode and turnaround errors, masking faults, busy-window leaks, sequencing order and divider ratio. A seeded random mix of reads, writes and extended writes then checks whole frames and read results against values the bench builds itself. It also checks the period measured at the last rising MDC edge against the expected one.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int RANGE_W = 2;
  localparam int DATA_W  = 16;
  localparam int REG_W   = 5;

  localparam int CMD_GO   = 0;
  localparam int CMD_WR   = 1;
  localparam int CMD_EXT  = 2;
  localparam int CMD_RNG  = 3;
  localparam int CMD_REG  = 8;

  localparam logic [REG_W-1:0]  IND_CTRL_REG = 5'h0D;
  localparam logic [REG_W-1:0]  IND_DATA_REG = 5'h0E;
  localparam logic [DATA_W-1:0] IND_FN_ADDR  = 16'h001F;
  localparam logic [DATA_W-1:0] IND_FN_DATA  = 16'h401F;

  typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_t;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int RANGE_W   = 2,
  parameter int BASE_HALF = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [RANGE_W-1:0] range_sel,
  output logic               mdc,
  output logic               rise_en,
  output logic               fall_en
);
  localparam int MAX_HALF = BASE_HALF << ((1 << RANGE_W) - 1);
  localparam int CNT_W    = $clog2(MAX_HALF) + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic             mdc_q, mdc_d, tick;

  always_comb begin
    lim   = CNT_W'((BASE_HALF << range_sel) - 1);
    tick  = run && (cnt_q == lim);
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      mdc_d = !mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc     = mdc_q;
  assign rise_en = tick && !mdc_q;
  assign fall_en = tick && mdc_q;
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
#(
  parameter int PRE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rd,
  input  logic [REG_W-1:0]  phy_addr,
  input  logic [REG_W-1:0]  reg_num,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_en,
  input  logic              fall_en,
  input  logic              mdio_i,
  output logic              active,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  localparam int FRAME_LEN = PRE_W + 32;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(FRAME_LEN - DATA_W - 2);
  localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(FRAME_LEN - DATA_W);

  logic                 active_q, active_d, rd_q, rd_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [FRAME_LEN-1:0] sh_q, sh_d;
  logic [DATA_W-1:0]    rsh_q, rsh_d;

  assign done = active_q && fall_en && (idx_q == LAST_IDX);

  always_comb begin
    active_d = active_q;
    rd_d     = rd_q;
    idx_d    = idx_q;
    sh_d     = sh_q;
    rsh_d    = rsh_q;
    if (start && !active_q) begin
      active_d = 1'b1;
      rd_d     = rd;
      idx_d    = '0;
      sh_d     = {{PRE_W{1'b1}}, 2'b01, (rd ? 2'b10 : 2'b01), phy_addr, reg_num,
                  2'b10, (rd ? {DATA_W{1'b0}} : wdata)};
    end else if (active_q) begin
      if (rise_en && rd_q && (idx_q >= DAT_IDX))
        rsh_d = {rsh_q[DATA_W-2:0], mdio_i};
      if (fall_en) begin
        if (idx_q == LAST_IDX) begin
          active_d = 1'b0;
        end else begin
          idx_d = idx_q + 1'b1;
          sh_d  = {sh_q[FRAME_LEN-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      idx_q    <= '0;
      sh_q     <= '0;
      rsh_q    <= '0;
    end else begin
      active_q <= active_d;
      rd_q     <= rd_d;
      idx_q    <= idx_d;
      sh_q     <= sh_d;
      rsh_q    <= rsh_d;
    end
  end

  assign active  = active_q;
  assign mdio_o  = sh_q[FRAME_LEN-1];
  assign mdio_oe = active_q && !(rd_q && (idx_q >= TA_IDX));
  assign rdata   = rsh_q;
endmodule

// File: rtl/mdio_ext_seq.sv
module mdio_ext_seq
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              ext,
  input  logic              cmd_wr,
  input  logic [REG_W-1:0]  cmd_reg,
  input  logic [DATA_W-1:0] tgt,
  input  logic [DATA_W-1:0] wdata,
  input  logic              frame_done,
  output logic              busy,
  output logic              frame_start,
  output logic              f_rd,
  output logic [REG_W-1:0]  f_reg,
  output logic [DATA_W-1:0] f_data,
  output logic              fin
);
  seq_state_t state_q, state_d;
  logic [1:0] step_q, step_d;
  logic       start_q, start_d;

  assign fin = (state_q == SEQ_RUN) && frame_done && (!ext || (step_q == 2'd3));

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    start_d = 1'b0;
    if (state_q == SEQ_IDLE) begin
      if (go) begin
        state_d = SEQ_RUN;
        step_d  = 2'd0;
        start_d = 1'b1;
      end
    end else if (frame_done) begin
      if (fin) begin
        state_d = SEQ_IDLE;
      end else begin
        step_d  = step_q + 1'b1;
        start_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      step_q  <= 2'd0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      start_q <= start_d;
    end
  end

  always_comb begin
    if (ext) begin
      f_rd  = 1'b0;
      f_reg = step_q[0] ? IND_DATA_REG : IND_CTRL_REG;
      case (step_q)
        2'd0:    f_data = IND_FN_ADDR;
        2'd1:    f_data = tgt;
        2'd2:    f_data = IND_FN_DATA;
        default: f_data = wdata;
      endcase
    end else begin
      f_rd   = !cmd_wr;
      f_reg  = cmd_reg;
      f_data = wdata;
    end
  end

  assign busy        = (state_q == SEQ_RUN);
  assign frame_start = start_q;
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter logic [4:0] PHY_ADDR  = 5'h01,
  parameter int         BASE_HALF = 4,
  parameter int         PRE_W     = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  input  logic        reg_rsel,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [1:0] rs_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  logic               wr_q, wr_d, ext_q, ext_d;
  logic [RANGE_W-1:0] rng_q, rng_d;
  logic [REG_W-1:0]   reg_q, reg_d;
  logic [DATA_W-1:0]  data_q, data_d, tgt_q, tgt_d;
  logic               busy, host_ok, go, fin, f_start, f_rd, f_active, f_done;
  logic               rise_en, fall_en;
  logic [REG_W-1:0]   f_reg;
  logic [DATA_W-1:0]  f_data, f_rdata;
  logic               unused_bits;

  assign unused_bits = ^{reg_wdata[31:16], reg_wdata[7:5]};
  assign host_ok     = reg_wr && !busy;
  assign go          = host_ok && !reg_sel && reg_wdata[CMD_GO];

  always_comb begin
    wr_d   = wr_q;
    ext_d  = ext_q;
    rng_d  = rng_q;
    reg_d  = reg_q;
    data_d = data_q;
    tgt_d  = tgt_q;
    if (host_ok && !reg_sel) begin
      wr_d  = reg_wdata[CMD_WR];
      ext_d = reg_wdata[CMD_EXT];
      rng_d = reg_wdata[CMD_RNG +: RANGE_W];
      reg_d = reg_wdata[CMD_REG +: REG_W];
    end else if (host_ok && reg_sel) begin
      data_d = reg_wdata[DATA_W-1:0];
      tgt_d  = reg_wdata[2*DATA_W-1:DATA_W];
    end else if (fin && !ext_q && !wr_q) begin
      data_d = f_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      wr_q   <= 1'b0;
      ext_q  <= 1'b0;
      rng_q  <= '0;
      reg_q  <= '0;
      data_q <= '0;
      tgt_q  <= '0;
    end else begin
      wr_q   <= wr_d;
      ext_q  <= ext_d;
      rng_q  <= rng_d;
      reg_q  <= reg_d;
      data_q <= data_d;
      tgt_q  <= tgt_d;
    end
  end

  assign reg_rdata = reg_rsel ? {tgt_q, data_q}
                              : {16'h0, 3'b000, reg_q, 3'b000, rng_q, ext_q, wr_q, busy};

  mdio_ext_seq u_seq (
    .clk(clk), .rst_n(rst_i), .go(go), .ext(ext_q), .cmd_wr(wr_q), .cmd_reg(reg_q),
    .tgt(tgt_q), .wdata(data_q), .frame_done(f_done), .busy(busy),
    .frame_start(f_start), .f_rd(f_rd), .f_reg(f_reg), .f_data(f_data), .fin(fin)
  );

  mdio_clkgen #(.RANGE_W(RANGE_W), .BASE_HALF(BASE_HALF)) u_clk (
    .clk(clk), .rst_n(rst_i), .run(f_active), .range_sel(rng_q),
    .mdc(mdc), .rise_en(rise_en), .fall_en(fall_en)
  );

  mdio_frame #(.PRE_W(PRE_W)) u_frame (
    .clk(clk), .rst_n(rst_i), .start(f_start), .rd(f_rd), .phy_addr(PHY_ADDR),
    .reg_num(f_reg), .wdata(f_data), .rise_en(rise_en), .fall_en(fall_en),
    .mdio_i(mdio_i), .active(f_active), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done(f_done), .rdata(f_rdata)
  );

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_i)
    f_start |-> !f_active);  // R1
  AST_BUSY_COVERS_WIRE: assert property (@(posedge clk) disable iff (!rst_i)
    f_active |-> busy);  // R1
  AST_CMD_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_i)
    (busy && reg_wr) |=> ($stable(reg_q) && $stable(wr_q) && $stable(ext_q) && $stable(rng_q) && $stable(tgt_q)));  // R2
  AST_DATA_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_i)
    (busy && $past(busy)) |-> $stable(data_q));  // R2
  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_i)
    !f_active |-> !mdc);  // R7
  AST_MDIO_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(mdc) |-> $stable(mdio_o));  // R8
endmodule

// File: tb/sim_mdio_mgmt_master.sv
module sim_mdio_mgmt_master;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] PHY = 5'h01;

  logic        clk, rst_n, reg_wr, reg_sel, reg_rsel;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  mdio_mgmt_master #(.PHY_ADDR(PHY)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rsel(reg_rsel), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc = cyc + 1;

  // PHY model
  int          cnt = 0;
  int          rise_t = 0;
  int          mdc_period = 0;
  int          fcount = 0;
  logic [63:0] cap = '0;
  logic [63:0] flog [4];
  logic        rd_flag = 1'b0;
  logic [15:0] rd_word = '0;
  logic [15:0] phy_regs [32];
  bit          oe_bad = 1'b0;
  wire         bitval = mdio_oe ? mdio_o : mdio_i;

  assign mdio_i = (rd_flag && cnt == 47) ? 1'b0 :
                  (rd_flag && cnt >= 48 && cnt <= 63) ? rd_word[4'(63 - cnt)] : 1'b1;

  always @(posedge mdc) begin
    logic [63:0] f;
    mdc_period = cyc - rise_t;
    rise_t = cyc;
    if (rd_flag && cnt >= 46 && mdio_oe) oe_bad = 1'b1;
    f = {cap[62:0], bitval};
    if (cnt == 35) rd_flag <= ({cap[0], bitval} == 2'b10);
    if (cnt == 46) rd_word <= phy_regs[cap[4:0]];
    cap <= f;
    if (cnt == 63) begin
      flog[3] <= flog[2]; flog[2] <= flog[1]; flog[1] <= flog[0]; flog[0] <= f;
      fcount <= fcount + 1;
      if (f[29:28] == 2'b01) phy_regs[f[22:18]] <= f[15:0];
      rd_flag <= 1'b0;
      cnt <= 0;
    end else begin
      cnt <= cnt + 1;
    end
  end

  int checks = 0;
  int fails = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), PHY, r, 2'b10, d};
  endfunction

  function automatic logic [31:0] mk_cmd(input bit go, input bit wr, input bit ext,
                                         input logic [1:0] rng, input logic [7:0] r8);
    return {16'h0, r8, 3'b000, rng, ext, wr, go};
  endfunction

  task automatic hw(input bit sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic hr(input bit sel, output logic [31:0] d);
    @(negedge clk);
    reg_rsel = sel;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    int n = 0;
    hr(1'b0, v);
    while (v[0] && n < 20000) begin
      hr(1'b0, v);
      n++;
    end
    if (v[0]) begin
      checks++; fails++;
      $display("FAIL R1 busy stuck actual=1 expected=0");
    end
  endtask

  task automatic run_write(input logic [1:0] rng, input logic [7:0] r8, input logic [15:0] d);
    int fc;
    hw(1'b1, {16'h0, d});
    fc = fcount;
    hw(1'b0, mk_cmd(1, 1, 0, rng, r8));
    wait_idle();
    chk("R4 write frame count", 64'(fcount), 64'(fc + 1));
    chk("R4 write frame bits", flog[0], exp_frame(0, r8[4:0], d));
  endtask

  task automatic run_read(input logic [1:0] rng, input logic [7:0] r8);
    logic [31:0] v;
    logic [15:0] e;
    e = phy_regs[r8[4:0]];
    oe_bad = 1'b0;
    hw(1'b0, mk_cmd(1, 0, 0, rng, r8));
    wait_idle();
    chk("R5 read frame bits", flog[0], exp_frame(1, r8[4:0], e));
    hr(1'b1, v);
    chk("R5 read result", 64'(v[15:0]), 64'(e));
    chk("R5 MDIO released", 64'(oe_bad), 64'(0));
  endtask

  task automatic run_ext(input logic [1:0] rng, input bit wrflag, input logic [15:0] t, input logic [15:0] d);
    int fc;
    hw(1'b1, {t, d});
    fc = fcount;
    hw(1'b0, mk_cmd(1, wrflag, 1, rng, 8'h00));
    wait_idle();
    chk("R6 ext frame count", 64'(fcount), 64'(fc + 4));
    chk("R6 ext step 1", flog[3], exp_frame(0, 5'h0D, 16'h001F));
    chk("R6 ext step 2", flog[2], exp_frame(0, 5'h0E, t));
    chk("R6 ext step 3", flog[1], exp_frame(0, 5'h0D, 16'h401F));
    chk("R6 ext step 4", flog[0], exp_frame(0, 5'h0E, d));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int fc;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 32; i++) phy_regs[i] = 16'(16'h1357 * (i + 1));
    reg_wr = 0; reg_sel = 0; reg_wdata = '0; reg_rsel = 0;
    rst_n = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R9 reset state
    hr(1'b0, v); chk("R9 command word", 64'(v), 64'(0));
    hr(1'b1, v); chk("R9 data word", 64'(v), 64'(0));
    chk("R9 mdc low", 64'(mdc), 64'(0));
    chk("R9 mdio released", 64'(mdio_oe), 64'(0));

    // R1 busy timing with directed write
    hw(1'b1, 32'h0000_BEEF);
    fc = fcount;
    hw(1'b0, mk_cmd(1, 1, 0, 2'd0, 8'h03));
    hr(1'b0, v); chk("R1 busy after start", 64'(v[0]), 64'(1));
    wait_idle();
    chk("R1 frame done when busy clears", 64'(fcount), 64'(fc + 1));
    chk("R1 mdc low when busy clears", 64'(mdc), 64'(0));
    chk("R4 directed write", flog[0], exp_frame(0, 5'h03, 16'hBEEF));

    // R3 register-number masking
    run_write(2'd0, 8'hE5, 16'hC0DE);
    hr(1'b0, v);
    chk("R3 reg readback", 64'(v[15:8]), 64'(8'h05));
    chk("R3 phy got low bits", 64'(phy_regs[5]), 64'(16'hC0DE));
    run_read(2'd0, 8'h05);

    // R2 writes during busy ignored
    fc = fcount;
    hw(1'b0, mk_cmd(1, 0, 0, 2'd1, 8'h02));
    repeat (20) @(negedge clk);
    hw(1'b0, mk_cmd(1, 1, 1, 2'd3, 8'h1F));
    hw(1'b1, 32'hAAAA_1234);
    wait_idle();
    chk("R2 one frame only", 64'(fcount), 64'(fc + 1));
    chk("R2 original frame", flog[0], exp_frame(1, 5'h02, phy_regs[2]));
    hr(1'b0, v);
    chk("R2 command unchanged", 64'(v), 64'(mk_cmd(0, 0, 0, 2'd1, 8'h02)));
    hr(1'b1, v);
    chk("R2 data is read result", 64'(v), 64'({16'h0, phy_regs[2]}));

    // R6 extended write, write flag clear
    run_ext(2'd0, 1'b0, 16'h0025, 16'h0008);

    // R7 clock ranges
    for (int r = 0; r < 4; r++) begin
      run_write(2'(r), 8'h10, 16'(16'h0F0F + r));
      chk("R7 mdc period", 64'(mdc_period), 64'(8 << r));
    end

    // Random mix
    for (int i = 0; i < 14; i++) begin
      int kind = int'($urandom % 3);
      logic [1:0] rng = 2'($urandom % 2);
      logic [7:0] r8 = 8'($urandom);
      logic [15:0] d = 16'($urandom);
      if (kind == 0) run_write(rng, r8, d);
      else if (kind == 1) run_read(rng, r8);
      else run_ext(rng, 1'($urandom), 16'($urandom), d);
      chk("R7 random period", 64'(mdc_period), 64'(8 << rng));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule